// File: doc/BRIEF.md
# Word-parallel additive data scrambler

This block whitens 32-bit payload words ahead of a serializer so that the line carries enough edge transitions. It also restores them after the deserializer. It XORs each data word with 32 consecutive bits of a pseudo-random sequence. The generator is the seven-stage polynomial 1 + x + x^7. All 32 bits are computed in one clock, so the block keeps up with one word per cycle. The operation is its own inverse, so the same module serves as scrambler at the transmit side and as descrambler at the receive side. The two ends stay aligned because the sequence restarts on marker words that both ends see unchanged.

Every word arrives with a 2-bit type code, and the code decides the treatment:
- Codes 01 and 10 mark data words, which are scrambled and advance the sequence.
- Code 11 marks a framing word (header, request, boundary or idle marker). It passes through untouched and restarts the sequence.
- Code 00 marks a filler word. It passes through untouched and leaves the sequence where it was.

A global enable input turns scrambling off entirely. The two overhead bits that travel with each word on the line are never part of this block's payload.

Top module: `wps_scrambler`

## Requirements
- R1: While reset is asserted, and in the cycle after it, out_valid, out_type and out_data are all zero. The generator holds its restart state, so the first data word after reset uses the same mask as the first data word after a code-11 word.
- R2: Output has one cycle of latency. out_valid equals in_valid of the previous cycle, and on a valid word out_type equals the in_type sent with it.
- R3: Each sequence bit is p[k] = p[k-1] XOR p[k-7]. After a restart, p[-7] to p[-1] are all ones. A data word (code 01 or 10) with en high leaves as in_data XOR mask, where mask bit 31 is the first unused sequence bit and bit 0 is the 32nd.
- R4: Successive data words use successive, non-overlapping 32-bit runs of the sequence. This holds across any number of idle cycles between them.
- R5: A code-11 word leaves unchanged and restarts the sequence. This happens whether en is high or low.
- R6: A code-00 word leaves unchanged and does not move the sequence position.
- R7: With en low, every word leaves unchanged, and data words do not move the sequence position.
- R8: A cycle with in_valid low produces out_valid low on the next cycle and does not move the sequence position.
- R9: A second instance fed with the first instance's outputs, and held at the same en, reproduces the original data and types exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Scrambling enable; low bypasses |
| in_valid | input | 1 | Input word present |
| in_type | input | 2 | Word type: 01/10 data, 11 marker with restart, 00 filler |
| in_data | input | 32 | Input payload word |
| out_valid | output | 1 | Output word present |
| out_type | output | 2 | Registered type code |
| out_data | output | 32 | Scrambled, descrambled or passed-through word |

## Verification
The properties take en to be steady across the cycles in which a word is in flight. The recovery property also takes it that both instances see the same type stream, so that their restarts line up. The stimulus changes en only after two idle cycles have drained both the scrambler and the chained descrambler. It then resumes with fresh words. Random runs mix all four type codes, with idle gaps between words, so that restarts, holds and advances occur in many orders. Directed runs also place data words right after reset and right after a marker.

// File: rtl/wps_scrambler.sv
module wps_scrambler #(
  parameter int DATA_W = 32,
  parameter int LFSR_W = 7,
  parameter int TAP    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [1:0]        in_type,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [1:0]        out_type,
  output logic [DATA_W-1:0] out_data
);
  localparam logic [LFSR_W-1:0] SEED = '1;

  // Returns {mask, next_state}; state bit 0 is the newest bit, bit LFSR_W-1 the oldest.
  function automatic logic [DATA_W+LFSR_W-1:0] run_seq(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] h;
    logic [DATA_W-1:0] m;
    logic              b;
    h = s;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      b = h[TAP-1] ^ h[LFSR_W-1];
      m[DATA_W-1-i] = b;
      h = {h[LFSR_W-2:0], b};
    end
    return {m, h};
  endfunction

  logic [LFSR_W-1:0] state;
  logic [DATA_W-1:0] mask;
  logic [LFSR_W-1:0] state_nxt;
  logic              is_data, is_mark, scr;

  assign {mask, state_nxt} = run_seq(state);
  assign is_data = in_type[1] ^ in_type[0];
  assign is_mark = &in_type;
  assign scr     = en & is_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEED;
      out_valid <= 1'b0;
      out_type  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_type <= in_type;
        out_data <= scr ? (in_data ^ mask) : in_data;
        if (is_mark)  state <= SEED;
        else if (scr) state <= state_nxt;
      end
    end
  end
endmodule

module wps_scrambler_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              in_valid,
  input logic [1:0]        in_type,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [1:0]        out_type,
  input logic [DATA_W-1:0] out_data
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_type == 2'b00 && out_data == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_type_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_type == $past(in_type));

  a_r5_marker_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_type == 2'b11) |=> out_data == $past(in_data));

  a_r6_filler_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_type == 2'b00) |=> out_data == $past(in_data));

  a_r7_bypass_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !en) |=> out_data == $past(in_data));

  a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

bind wps_scrambler wps_scrambler_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_type(in_type),
  .in_data(in_data), .out_valid(out_valid), .out_type(out_type), .out_data(out_data)
);

// File: tb/wps_scrambler_tb_top.sv
module wps_scrambler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 127;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_type = 2'b00;
  logic [31:0] in_data = '0;
  logic        s_valid, d_valid;
  logic [1:0]  s_type, d_type;
  logic [31:0] s_data, d_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  wps_scrambler dut_i (.clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
    .in_type(in_type), .in_data(in_data), .out_valid(s_valid), .out_type(s_type),
    .out_data(s_data));

  wps_scrambler dsc_i (.clk(clk), .rst_n(rst_n), .en(en), .in_valid(s_valid),
    .in_type(s_type), .in_data(s_data), .out_valid(d_valid), .out_type(d_type),
    .out_data(d_data));

  int n_chk = 0, n_fail = 0;
  bit seq [PER];
  int pos = 0;

  logic        qv[$];
  logic [1:0]  qt[$];
  logic [31:0] qd[$];
  logic [31:0] qo[$];
  string       qr[$];
  logic        rv[$];
  logic [1:0]  rt[$];
  logic [31:0] ro[$];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    bit ext [PER+7];
    for (int j = 0; j < 7; j++) ext[j] = 1'b1;
    for (int j = 7; j < PER+7; j++) ext[j] = ext[j-1] ^ ext[j-7];
    for (int k = 0; k < PER; k++) seq[k] = ext[k+7];
  end

  task automatic send(logic v, logic [1:0] t, logic [31:0] d, string req);
    logic [31:0] e;
    @(negedge clk);
    in_valid = v; in_type = t; in_data = d;
    e = d;
    if (v) begin
      if (t == 2'b11) pos = 0;
      else if (t != 2'b00 && en) begin
        for (int i = 0; i < 32; i++) e[31-i] = d[31-i] ^ seq[(pos+i) % PER];
        pos = (pos + 32) % PER;
      end
    end
    qv.push_back(v); qt.push_back(t); qd.push_back(e); qo.push_back(d); qr.push_back(req);
  endtask

  task automatic set_en(logic val);
    send(1'b0, 2'b00, 32'h0, "R8");
    send(1'b0, 2'b00, 32'h0, "R8");
    @(negedge clk);
    en = val;
    send(1'b0, 2'b00, 32'h0, "R8");
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (rv.size() > 0) begin
        logic v; logic [1:0] t; logic [31:0] o;
        v = rv.pop_front(); t = rt.pop_front(); o = ro.pop_front();
        check("R9 valid", {63'b0, d_valid}, {63'b0, v});
        if (v) check("R9 recovery", {30'b0, d_type, d_data}, {30'b0, t, o});
      end
      if (qv.size() > 0) begin
        logic v; logic [1:0] t; logic [31:0] e, o; string r;
        v = qv.pop_front(); t = qt.pop_front(); e = qd.pop_front();
        o = qo.pop_front(); r = qr.pop_front();
        check({r, " valid"}, {63'b0, s_valid}, {63'b0, v});
        if (v) check({r, " word"}, {30'b0, s_type, s_data}, {30'b0, t, e});
        rv.push_back(v); rt.push_back(t); ro.push_back(o);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {29'b0, s_valid, s_type, s_data}, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    // R1: first data word after reset uses restart mask
    send(1'b1, 2'b01, 32'h0000_0000, "R1");
    send(1'b1, 2'b10, 32'hFFFF_FFFF, "R4");
    send(1'b0, 2'b00, 32'h1234_5678, "R8");
    send(1'b1, 2'b01, 32'hA5A5_A5A5, "R4");
    send(1'b1, 2'b00, 32'hDEAD_BEEF, "R6");
    send(1'b1, 2'b10, 32'h0F0F_0F0F, "R6");
    send(1'b1, 2'b11, 32'hCAFE_F00D, "R5");
    send(1'b1, 2'b01, 32'h0000_0000, "R3");
    send(1'b1, 2'b01, 32'h0000_0000, "R3");
    for (int i = 0; i < 6; i++) send(1'b1, 2'b10, $urandom, "R4");
    set_en(1'b0);
    send(1'b1, 2'b01, 32'h1357_9BDF, "R7");
    send(1'b1, 2'b10, 32'h2468_ACE0, "R7");
    send(1'b1, 2'b11, 32'h7777_0000, "R5");
    send(1'b1, 2'b01, 32'h5555_AAAA, "R7");
    set_en(1'b1);
    send(1'b1, 2'b01, 32'h0000_0000, "R5");
    for (int i = 0; i < 400; i++)
      send(1'($urandom_range(0, 4) != 0), 2'($urandom), $urandom, "R3");
    set_en(1'b0);
    for (int i = 0; i < 100; i++)
      send(1'($urandom_range(0, 3) != 0), 2'($urandom), $urandom, "R7");
    set_en(1'b1);
    for (int i = 0; i < 200; i++)
      send(1'b1, 2'($urandom), $urandom, "R9");
    repeat (4) send(1'b0, 2'b00, 32'h0, "R8");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule